// File: doc/BRIEF.md
# Block Register Transfer Sequencer

This block runs the multi-register load and store operations of a 32-bit processor that has sixteen architectural registers, the last of which is the program counter. A single start pulse hands it the following inputs:

- a 16-bit register selection mask;
- a starting address;
- the expected final address;
- a load/store direction flag;
- the index of the base register;
- the condition-passed flag;
- the current fetch PC.

The block walks the mask from the lowest bit upward. It issues one word-sized memory access per selected register over a request/acknowledge port. For a load it writes the returned word into the register file. For a store it reads the register file and sends the value to memory.

For stores, the base register's value is sampled in the start cycle and stays frozen. If the base register is in the list, it is stored with that original value. On a load that includes the program counter, the returned word goes to the PC with bit 0 cleared. If that bit was set, the block raises a sticky alternate-mode flag and pulses a fault with completion. When the PC is not loaded, the block writes fetch PC + 4 at completion. It also compares the last address it used against the expected end address and latches a mismatch error.

The controller has three states:

- **IDLE**: waits for start.
  - START_RUN goes to XFER when the condition passed and the mask is non-empty.
  - START_SKIP goes straight to FINISH otherwise.
- **XFER**: keeps one request outstanding until it is acknowledged.
  - XFER_NEXT stays in XFER while selected bits remain.
  - XFER_LAST goes to FINISH on the acknowledge of the final one.
- **FINISH**: pulses done for one cycle and applies the sequential PC update.
  - FINISH_RET returns to IDLE.

Top module: `blkxfer_seq`

## Requirements
- R1: When `cond_ok` is low at start, done pulses in the following cycle with no memory request, no register-file write and no PC write.
- R2: Mask bits are served in ascending index order, and each set bit produces exactly one acknowledged memory access.
- R3: The first access uses `start_addr`, and each later access uses the previous address plus 4.
- R4: A store sends the current register-file value of the selected register. When the selected index equals `base_idx`, it sends instead the value that register held in the start cycle.
- R5: A load writes registers 0 to 14 through the register write port with the word returned, in the acknowledge cycle. Index 15 is never written through that port.
- R6: A load whose mask has bit 15 set writes the PC (`pc_we`) in the acknowledge cycle of that access, with the returned word and bit 0 forced to 0.
- R7: If bit 0 of the word loaded into the PC is 1, `alt_mode` rises and stays high until reset, and `mode_fault` is high in the done cycle of that operation.
- R8: When the condition passed and bit 15 was not loaded, the done cycle carries `pc_we` with `pc_wdata` equal to the captured `fetch_pc` + 4.
- R9: If the address of the final access differs from `end_addr`, `end_mismatch` is high by the done cycle and stays high until reset. A matching address leaves it low.
- R10: `mem_req` stays high with unchanged address and direction until `mem_ack`. `done` is never high for two cycles in a row.
- R11: An empty mask with `cond_ok` high makes no memory access, and `done` appears in the cycle right after start with the fetch PC + 4 update.
- R12: Synchronous reset returns the block to IDLE with `mem_req`, `done`, `alt_mode` and `end_mismatch` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation (sampled in IDLE) |
| is_load | input | 1 | 1 = load from memory, 0 = store to memory |
| cond_ok | input | 1 | Condition-passed flag |
| base_idx | input | 4 | Base register index |
| start_addr | input | 32 | Address of the first transfer |
| end_addr | input | 32 | Expected address of the final transfer |
| reg_mask | input | 16 | Register selection mask, bit n = register n |
| fetch_pc | input | 32 | Fetch PC of the instruction |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (store) |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Store data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Load data, valid with `mem_ack` |
| rf_raddr | output | 4 | Register-file read index |
| rf_rdata | input | 32 | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 4 | Register-file write index |
| rf_wdata | output | 32 | Register-file write data |
| pc_we | output | 1 | PC write enable |
| pc_wdata | output | 32 | New PC value |
| done | output | 1 | One-cycle completion pulse |
| mode_fault | output | 1 | Unsupported-mode fault, valid with `done` |
| alt_mode | output | 1 | Sticky alternate-mode flag |
| end_mismatch | output | 1 | Sticky end-address error |

## Verification
The store test includes the base register in the list and overwrites that register in the bench right after start. A design that reads it live would store the new value instead of the frozen one.

Load tests run with memory latency of several cycles. This exposes designs that advance the address or write a register before the acknowledge. Designs that let the mask scan skip or repeat a bit show the wrong register contents.

PC loads are tried with an even word and an odd word. A design that does not clear bit 0 shows the wrong PC, and one that misses the fault leaves the flag low. A design that also writes register 15 through the register port shows an extra register write.

Other cases cover:
- a deliberately wrong end address, where a design that never compares fails to raise the error;
- a failed condition, where any access or PC write is an error;
- an empty mask, where completion must come one cycle after start with the +4 PC.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_XFER   = 2'd1,
        ST_FINISH = 2'd2
    } seq_state_t;

endpackage

// File: rtl/blkxfer_scan.sv
module blkxfer_scan #(
    parameter int NREGS = 16,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic [NREGS-1:0] pending,
    output logic [IDX_W-1:0] low_idx,
    output logic [NREGS-1:0] low_bit,
    output logic             any_set
);

    // Lowest pending bit wins: scan from the top so the last hit is the lowest.
    always_comb begin
        low_idx = '0;
        for (int i = NREGS - 1; i >= 0; i--) begin
            if (pending[i]) begin
                low_idx = IDX_W'(i);
            end
        end
    end

    assign low_bit = pending & (~pending + 1'b1);
    assign any_set = |pending;

endmodule

// File: rtl/blkxfer_pcfix.sv
module blkxfer_pcfix #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] target,
    output logic              odd
);

    assign target = {word[DATA_W-1:1], 1'b0};
    assign odd    = word[0];

endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq #(
    parameter int DATA_W = 32,
    parameter int NREGS  = 16,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              is_load,
    input  logic              cond_ok,
    input  logic [IDX_W-1:0]  base_idx,
    input  logic [DATA_W-1:0] start_addr,
    input  logic [DATA_W-1:0] end_addr,
    input  logic [NREGS-1:0]  reg_mask,
    input  logic [DATA_W-1:0] fetch_pc,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [IDX_W-1:0]  rf_raddr,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              rf_we,
    output logic [IDX_W-1:0]  rf_waddr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              pc_we,
    output logic [DATA_W-1:0] pc_wdata,
    output logic              done,
    output logic              mode_fault,
    output logic              alt_mode,
    output logic              end_mismatch
);
    import blkxfer_pkg::*;

    localparam logic [IDX_W-1:0]  PC_IDX = IDX_W'(NREGS - 1);
    localparam logic [DATA_W-1:0] STEP   = DATA_W'(DATA_W / 8);

    seq_state_t        state_q;
    logic [NREGS-1:0]  mask_q;
    logic [DATA_W-1:0] addr_q;
    logic [DATA_W-1:0] end_q;
    logic [DATA_W-1:0] fetch_q;
    logic [DATA_W-1:0] base_q;
    logic [IDX_W-1:0]  base_idx_q;
    logic              load_q;
    logic              run_q;
    logic              pc_loaded_q;
    logic              pc_odd_q;
    logic              mode_q;
    logic              err_q;

    logic [IDX_W-1:0]  cur_idx;
    logic [NREGS-1:0]  cur_bit;
    logic              mask_any;
    logic [DATA_W-1:0] pc_target;
    logic              pc_odd;
    logic              last_xfer;

    blkxfer_scan #(.NREGS(NREGS)) u_scan (
        .pending (mask_q),
        .low_idx (cur_idx),
        .low_bit (cur_bit),
        .any_set (mask_any)
    );

    blkxfer_pcfix #(.DATA_W(DATA_W)) u_pcfix (
        .word   (mem_rdata),
        .target (pc_target),
        .odd    (pc_odd)
    );

    assign last_xfer = ((mask_q & ~cur_bit) == '0);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= (cond_ok && (|reg_mask)) ? ST_XFER : ST_FINISH;
                    end
                end
                ST_XFER: begin
                    if (mem_ack && last_xfer) begin
                        state_q <= ST_FINISH;
                    end
                end
                ST_FINISH: state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    // Operation context and flags
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q      <= '0;
            addr_q      <= '0;
            end_q       <= '0;
            fetch_q     <= '0;
            base_q      <= '0;
            base_idx_q  <= '0;
            load_q      <= 1'b0;
            run_q       <= 1'b0;
            pc_loaded_q <= 1'b0;
            pc_odd_q    <= 1'b0;
            mode_q      <= 1'b0;
            err_q       <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                mask_q      <= cond_ok ? reg_mask : '0;
                addr_q      <= start_addr;
                end_q       <= end_addr;
                fetch_q     <= fetch_pc;
                base_q      <= rf_rdata;
                base_idx_q  <= base_idx;
                load_q      <= is_load;
                run_q       <= cond_ok;
                pc_loaded_q <= 1'b0;
                pc_odd_q    <= 1'b0;
            end else if (state_q == ST_XFER && mem_ack && mask_any) begin
                mask_q <= mask_q & ~cur_bit;
                addr_q <= addr_q + STEP;
                if (load_q && cur_idx == PC_IDX) begin
                    pc_loaded_q <= 1'b1;
                    if (pc_odd) begin
                        pc_odd_q <= 1'b1;
                        mode_q   <= 1'b1;
                    end
                end
                if (last_xfer && addr_q != end_q) begin
                    err_q <= 1'b1;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        rf_raddr   = base_idx;
        rf_we      = 1'b0;
        rf_waddr   = '0;
        rf_wdata   = '0;
        pc_we      = 1'b0;
        pc_wdata   = '0;
        done       = 1'b0;
        mode_fault = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_XFER: begin
                rf_raddr  = cur_idx;
                mem_req   = 1'b1;
                mem_we    = !load_q;
                mem_addr  = addr_q;
                mem_wdata = (cur_idx == base_idx_q) ? base_q : rf_rdata;
                if (mem_ack && load_q) begin
                    if (cur_idx == PC_IDX) begin
                        pc_we    = 1'b1;
                        pc_wdata = pc_target;
                    end else begin
                        rf_we    = 1'b1;
                        rf_waddr = cur_idx;
                        rf_wdata = mem_rdata;
                    end
                end
            end
            ST_FINISH: begin
                done       = 1'b1;
                mode_fault = pc_odd_q;
                if (run_q && !pc_loaded_q) begin
                    pc_we    = 1'b1;
                    pc_wdata = fetch_q + STEP;
                end
            end
            default: ;
        endcase
    end

    assign alt_mode     = mode_q;
    assign end_mismatch = err_q;

    // R1: failed condition completes without side effects
    a_r1_skip_quiet: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && start && !cond_ok) |=> (done && !mem_req && !pc_we && !rf_we));

    // R2: each acknowledged access retires exactly one mask bit
    a_r2_one_bit_per_ack: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack) |=> ($countones(mask_q) == $countones($past(mask_q)) - 1));

    // R3: consecutive accesses are one word apart
    a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack) |=> (!mem_req || mem_addr == $past(mem_addr) + STEP));

    // R7: alternate-mode flag is sticky
    a_r7_mode_sticky: assert property (@(posedge clk) disable iff (rst)
        alt_mode |=> alt_mode);

    // R9: end-address error is sticky
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
        end_mismatch |=> end_mismatch);

    // R10: request held stable until acknowledged
    a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R10: done lasts a single cycle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11: empty mask finishes next cycle with the sequential PC
    a_r11_empty_mask: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && start && cond_ok && reg_mask == '0)
        |=> (done && pc_we && pc_wdata == $past(fetch_pc) + STEP));

endmodule

// File: tb/tb_blkxfer_seq.sv
`timescale 1ns/1ps
module tb_blkxfer_seq;

    logic        clk = 1'b0;
    logic        rst;
    logic        start, is_load, cond_ok;
    logic [3:0]  base_idx;
    logic [31:0] start_addr, end_addr, fetch_pc;
    logic [15:0] reg_mask;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  rf_raddr, rf_waddr;
    logic [31:0] rf_rdata, rf_wdata, pc_wdata;
    logic        rf_we, pc_we, done, mode_fault, alt_mode, end_mismatch;

    logic [31:0] regs [0:15];
    logic [31:0] mem  [0:63];
    logic [31:0] log_addr [0:31];
    logic [31:0] log_data [0:31];
    logic        log_we   [0:31];
    int          log_n, rf_wr_n, pc_wr_n, done_n;
    logic [31:0] pc_last;
    logic        fault_seen, err_seen, flag_seen;
    int          cyc, done_cyc, start_cyc;
    int          lat;
    int          checks, fails;
    bit          finished;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign rf_rdata = regs[rf_raddr];

    blkxfer_seq dut (
        .clk(clk), .rst(rst), .start(start), .is_load(is_load), .cond_ok(cond_ok),
        .base_idx(base_idx), .start_addr(start_addr), .end_addr(end_addr),
        .reg_mask(reg_mask), .fetch_pc(fetch_pc),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata), .pc_we(pc_we), .pc_wdata(pc_wdata), .done(done),
        .mode_fault(mode_fault), .alt_mode(alt_mode), .end_mismatch(end_mismatch)
    );

    // Memory responder and write monitor, acting half a cycle from the edge
    initial begin
        int wait_cnt;
        wait_cnt = 0;
        mem_ack = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (wait_cnt >= lat) begin
                    mem_ack   = 1'b1;
                    mem_rdata = mem[mem_addr[7:2]];
                    wait_cnt  = 0;
                end else begin
                    wait_cnt++;
                end
            end else begin
                wait_cnt = 0;
            end
            #1;
            if (mem_req && mem_ack && log_n < 32) begin
                log_addr[log_n] = mem_addr;
                log_we[log_n]   = mem_we;
                log_data[log_n] = mem_we ? mem_wdata : mem_rdata;
                if (mem_we) mem[mem_addr[7:2]] = mem_wdata;
                log_n++;
            end
            if (rf_we) begin
                regs[rf_waddr] = rf_wdata;
                rf_wr_n++;
            end
            if (pc_we) begin
                pc_last = pc_wdata;
                pc_wr_n++;
            end
            if (done) begin
                done_n++;
                fault_seen = mode_fault;
                err_seen   = end_mismatch;
                flag_seen  = alt_mode;
                done_cyc   = cyc;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #2;
    endtask

    task automatic run_op(input logic ld, input logic cnd, input logic [3:0] bidx,
                          input logic [31:0] sa, input logic [31:0] ea,
                          input logic [15:0] msk, input logic [31:0] fpc,
                          input bit poke, input logic [31:0] poke_val);
        int d0;
        int k;
        log_n = 0; rf_wr_n = 0; pc_wr_n = 0;
        fault_seen = 1'b0; err_seen = 1'b0; flag_seen = 1'b0;
        d0 = done_n;
        @(negedge clk);
        is_load = ld; cond_ok = cnd; base_idx = bidx; start_addr = sa;
        end_addr = ea; reg_mask = msk; fetch_pc = fpc; start = 1'b1;
        start_cyc = cyc;
        @(negedge clk);
        start = 1'b0;
        if (poke) regs[bidx] = poke_val;
        #2;
        k = 0;
        while (done_n == d0 && k < 400) begin
            @(negedge clk);
            #2;
            k++;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R12 mem_req", {31'b0, mem_req}, 32'd0);
        chk("R12 done", {31'b0, done}, 32'd0);
        chk("R12 alt_mode", {31'b0, alt_mode}, 32'd0);
        chk("R12 end_mismatch", {31'b0, end_mismatch}, 32'd0);
    endtask

    // Store of r0,r2,r5,r15 with base r2 modified after start
    task automatic t_store_base();
        lat = 0;
        run_op(1'b0, 1'b1, 4'd2, 32'h40, 32'h4C, 16'h8025, 32'h200, 1'b1, 32'hDEAD_0002);
        chk("R2 store count", log_n, 4);
        chk("R3 addr0", log_addr[0], 32'h40);
        chk("R3 addr3", log_addr[3], 32'h4C);
        chk("R2/R4 data r0", log_data[0], 32'h1000);
        chk("R4 base r2 original", log_data[1], 32'h1022);
        chk("R2/R4 data r5", log_data[2], 32'h1055);
        chk("R2/R4 data r15", log_data[3], 32'h10FF);
        chk("R4 write dir", {31'b0, log_we[3]}, 32'd1);
        chk("R8 pc writes", pc_wr_n, 1);
        chk("R8 pc value", pc_last, 32'h204);
        chk("R9 no error", {31'b0, err_seen}, 32'd0);
        regs[2] = 32'h1022;
    endtask

    task automatic t_load_slow();
        lat = 2;
        run_op(1'b1, 1'b1, 4'd1, 32'h80, 32'h8C, 16'h0A0C, 32'h300, 1'b0, 32'h0);
        chk("R2 load count", log_n, 4);
        chk("R3 load addr2", log_addr[2], 32'h88);
        chk("R5 r2", regs[2], 32'hA500_0080);
        chk("R5 r3", regs[3], 32'hA500_0084);
        chk("R5 r9", regs[9], 32'hA500_0088);
        chk("R5 r11", regs[11], 32'hA500_008C);
        chk("R5 r4 untouched", regs[4], 32'h1044);
        chk("R5 rf writes", rf_wr_n, 4);
        chk("R8 pc after load", pc_last, 32'h304);
        chk("R10 no mem write", {31'b0, log_we[0]}, 32'd0);
    endtask

    task automatic t_load_pc_even();
        lat = 1;
        mem[6'h31] = 32'h0000_2468;
        run_op(1'b1, 1'b1, 4'd0, 32'hC0, 32'hC4, 16'h8001, 32'h400, 1'b0, 32'h0);
        chk("R5 r0", regs[0], 32'hA500_00C0);
        chk("R5 rf writes no r15", rf_wr_n, 1);
        chk("R6 pc writes", pc_wr_n, 1);
        chk("R6 pc value", pc_last, 32'h2468);
        chk("R7 no fault", {31'b0, fault_seen}, 32'd0);
        chk("R7 no flag", {31'b0, flag_seen}, 32'd0);
    endtask

    task automatic t_load_pc_odd();
        lat = 0;
        mem[6'h34] = 32'h0000_1357;
        run_op(1'b1, 1'b1, 4'd0, 32'hD0, 32'hD0, 16'h8000, 32'h500, 1'b0, 32'h0);
        chk("R6 pc cleared bit0", pc_last, 32'h1356);
        chk("R6 pc writes", pc_wr_n, 1);
        chk("R7 fault", {31'b0, fault_seen}, 32'd1);
        chk("R7 flag", {31'b0, flag_seen}, 32'd1);
        chk("R7 flag sticky", {31'b0, alt_mode}, 32'd1);
        do_reset();
        chk("R12 flag cleared", {31'b0, alt_mode}, 32'd0);
    endtask

    task automatic t_end_mismatch();
        lat = 0;
        run_op(1'b0, 1'b1, 4'd9, 32'h60, 32'h60, 16'h0003, 32'h600, 1'b0, 32'h0);
        chk("R2 two stores", log_n, 2);
        chk("R9 error at done", {31'b0, err_seen}, 32'd1);
        chk("R9 error sticky", {31'b0, end_mismatch}, 32'd1);
        do_reset();
        chk("R12 error cleared", {31'b0, end_mismatch}, 32'd0);
    endtask

    task automatic t_cond_fail();
        int d0;
        lat = 0;
        d0 = done_n;
        run_op(1'b1, 1'b0, 4'd0, 32'h80, 32'h9C, 16'h00FF, 32'h700, 1'b0, 32'h0);
        chk("R1 done once", done_n - d0, 1);
        chk("R1 no access", log_n, 0);
        chk("R1 no rf write", rf_wr_n, 0);
        chk("R1 no pc write", pc_wr_n, 0);
    endtask

    task automatic t_empty_mask();
        lat = 0;
        run_op(1'b1, 1'b1, 4'd0, 32'h80, 32'h80, 16'h0000, 32'h800, 1'b0, 32'h0);
        chk("R11 no access", log_n, 0);
        chk("R11 pc", pc_last, 32'h804);
        chk("R11 latency", done_cyc - start_cyc, 1);
        chk("R11 no error", {31'b0, err_seen}, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) regs[i] = 32'h1000 + i * 32'h11;
        for (int i = 0; i < 64; i++) mem[i] = 32'hA500_0000 + i * 4;
        rst = 1'b1; start = 1'b0; is_load = 1'b0; cond_ok = 1'b0; base_idx = '0;
        start_addr = '0; end_addr = '0; reg_mask = '0; fetch_pc = '0;
        log_n = 0; rf_wr_n = 0; pc_wr_n = 0; done_n = 0; pc_last = '0;
        fault_seen = 1'b0; err_seen = 1'b0; flag_seen = 1'b0;
        cyc = 0; done_cyc = 0; start_cyc = 0; lat = 0;
        checks = 0; fails = 0; finished = 1'b0;
        t_reset_state();
        t_store_base();
        t_load_slow();
        t_load_pc_even();
        t_load_pc_odd();
        t_end_mismatch();
        t_cond_fail();
        t_empty_mask();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule